// File: doc/BRIEF.md
# Chained Counter Watchdog Timer

This block is a register-mapped timer with a parameterised number of 64-bit down-counters, two by default. Each counter carries its own control word with an enable, a mode, a trigger-source selector and an 8-bit prescale divisor, plus a 64-bit reload value. A counter either runs once when it is enabled or, in the triggered mode, waits for an end-count event from the counter below it and then reloads and restarts on every such event.

The watchdog is built from that chaining. Counter 1 runs in triggered mode and is fed by counter 0. Software services the watchdog by switching counter 0 off and on again. Counter 0 holds a reload of zero, so each fresh enable ends at once and restarts counter 1. A select register names which counter's expiry drives the reset output. When the named counter runs down, the block emits a one-clock reset pulse and sets a sticky flag. The flag stays set until the select register is written again.

Top module: `chained_wdt`

## Requirements
- R1: Counter i owns addresses i*0x10 (control), i*0x10+0x4 (reload bits 31:0) and i*0x10+0x8 (reload bits 63:32). The select register sits at 0x80. A read registers its data on `bus_rdata` at the clock edge where `bus_rd` is sampled, and the reload words read back as written.
- R2: The control word has enable in bit 0, a read-only running flag in bit 1, the mode in bits 3:2, the trigger source in bits 7:4 and the prescale divisor in bits 15:8. Reads return these fields with the upper bits zero.
- R3: In mode 0 (one-shot), the edge at which enable turns from 0 to 1 loads the reload value N. The count drops once every P clocks. `cnt_end_o[i]` pulses for one clock 1+N*P clock edges after the edge that wrote the enable, so a reload of 0 ends on the very next edge.
- R4: A prescale divisor below 2 behaves as 2.
- R5: In mode 3 (triggered), an enabled counter idles with its running flag clear until a trigger arrives. Trigger source 5 means the end-count pulse of counter i-1. Every trigger reloads and restarts the counter, including a trigger that arrives while it is running, and the running flag reads 1 while it counts.
- R6: With counter 0 in one-shot mode holding reload 0, and counter 1 in triggered mode with source 5, divisor P and reload N, `wdt_rst_o` rises 3+N*P edges after the edge that re-enables counter 0. A second kick restarts that interval.
- R7: Select bit i makes counter i the watchdog. Expiry of a selected, enabled counter gives a `wdt_rst_o` pulse one clock long. With select equal to 0, counters still end but `wdt_rst_o` stays low.
- R8: `wdt_flag_o` goes high together with the reset pulse and holds until the next write to the select register.
- R9: Clearing enable stops a counter, clears its running flag and suppresses its end-count pulse.
- R10: After reset, all registers, `bus_rdata`, `cnt_end_o`, `wdt_rst_o` and `wdt_flag_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| cnt_end_o | output | NUM_CNT | One-clock end-count pulse per counter |
| wdt_rst_o | output | 1 | One-clock watchdog reset pulse |
| wdt_flag_o | output | 1 | Sticky watchdog expiry flag |

## Verification
The main check walks a table of divisor and reload pairs through the full kick path and measures the interval from kick to reset. A zero reload separates the fixed pipeline latency from the counting. Divisors of 0 and 1 confirm that the clamp applies, and divisors 3 and 8 confirm that the divisor multiplies the reload and does not add to it. Directed cases cover a kick in the middle of a run, which tells restart apart from continuation, and a select of zero, which tells counter expiry apart from reset generation. They also cover one-shot runs with zero and non-zero reloads, a disable partway through a run, and a triggered counter left idle without its trigger.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PS_W      = 8;
  localparam int OFS_CTRL  = 0;
  localparam int OFS_LO    = 4;
  localparam int OFS_HI    = 8;
  localparam int WIN_BYTES = 16;
  localparam logic [1:0] MODE_HWTRIG = 2'd3;
  localparam logic [3:0] TRIG_PREV   = 4'd5;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic              trig_in,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [CNT_W-1:0]  reload_o,
  output logic              end_o,
  output logic              en_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic             en, en_q, active, end_q;
  logic [1:0]       mode;
  logic [3:0]       trig_sel;
  logic [PS_W-1:0]  ps, pre, ps_eff;
  logic [CNT_W-1:0] reload, cnt;
  logic             trig_hit, start;

  assign ps_eff   = (ps < PS_W'(2)) ? PS_W'(2) : ps;
  assign trig_hit = (trig_sel == TRIG_PREV) && trig_in;
  assign start    = en && ((mode != MODE_HWTRIG && !en_q) ||
                           (mode == MODE_HWTRIG && trig_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; en_q <= 1'b0; active <= 1'b0; end_q <= 1'b0;
      mode <= '0; trig_sel <= '0; ps <= '0; pre <= '0;
      reload <= '0; cnt <= '0;
    end else begin
      en_q  <= en;
      end_q <= 1'b0;
      if (wr_ctrl) begin
        en       <= wdata[0];
        mode     <= wdata[3:2];
        trig_sel <= wdata[7:4];
        ps       <= wdata[15:8];
      end
      if (wr_lo) reload[DATA_W-1:0] <= wdata;
      if (wr_hi) reload[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      if (!en) begin
        active <= 1'b0;
      end else if (start) begin
        if (reload == '0) begin
          end_q  <= 1'b1;
          active <= 1'b0;
        end else begin
          cnt    <= reload;
          pre    <= '0;
          active <= 1'b1;
        end
      end else if (active) begin
        if (pre == PS_W'(ps_eff - PS_W'(1))) begin
          pre <= '0;
          if (cnt == CNT_W'(1)) begin
            cnt    <= '0;
            active <= 1'b0;
            end_q  <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end else begin
          pre <= pre + PS_W'(1);
        end
      end
    end
  end

  assign ctrl_rd  = {{(DATA_W-16){1'b0}}, ps, trig_sel, mode, active, en};
  assign reload_o = reload;
  assign end_o    = end_q;
  assign en_o     = en;
endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen #(
  parameter int NUM_CNT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_wr,
  input  logic [NUM_CNT-1:0] sel_wdata,
  input  logic [NUM_CNT-1:0] cnt_end,
  input  logic [NUM_CNT-1:0] cnt_en,
  output logic [NUM_CNT-1:0] sel_o,
  output logic               rst_o,
  output logic               flag_o
);
  logic fire;
  assign fire = |(cnt_end & sel_o & cnt_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o  <= '0;
      rst_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      rst_o <= fire;
      if (sel_wr) sel_o <= sel_wdata;
      if (fire) flag_o <= 1'b1;
      else if (sel_wr) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/chained_wdt.sv
module chained_wdt
  import wdt_pkg::*;
#(
  parameter int NUM_CNT  = 2,
  parameter int CNT_W    = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int SEL_ADDR = 'h80
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_CNT-1:0] cnt_end_o,
  output logic               wdt_rst_o,
  output logic               wdt_flag_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0]  ctrl_rd [NUM_CNT];
  logic [CNT_W-1:0]   reload  [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_end, cnt_en, trig, sel_q;
  logic [DATA_W-1:0]  rd_mux;
  logic               sel_wr;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(i * WIN_BYTES);
    if (i == 0) begin : g_first
      assign trig[i] = 1'b0;
    end else begin : g_chain
      assign trig[i] = cnt_end[i-1];
    end
    wdt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .wr_ctrl (bus_wr && bus_addr == BASE + ADDR_W'(OFS_CTRL)),
      .wr_lo   (bus_wr && bus_addr == BASE + ADDR_W'(OFS_LO)),
      .wr_hi   (bus_wr && bus_addr == BASE + ADDR_W'(OFS_HI)),
      .wdata   (bus_wdata),
      .trig_in (trig[i]),
      .ctrl_rd (ctrl_rd[i]),
      .reload_o(reload[i]),
      .end_o   (cnt_end[i]),
      .en_o    (cnt_en[i])
    );
  end

  assign sel_wr = bus_wr && bus_addr == ADDR_W'(SEL_ADDR);

  wdt_rstgen #(.NUM_CNT(NUM_CNT)) u_rst (
    .clk      (clk),
    .rst      (rst),
    .sel_wr   (sel_wr),
    .sel_wdata(bus_wdata[NUM_CNT-1:0]),
    .cnt_end  (cnt_end),
    .cnt_en   (cnt_en),
    .sel_o    (sel_q),
    .rst_o    (wdt_rst_o),
    .flag_o   (wdt_flag_o)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(SEL_ADDR)) rd_mux = DATA_W'(sel_q);
    for (int i = 0; i < NUM_CNT; i++) begin
      if (bus_addr == ADDR_W'(i * WIN_BYTES + OFS_CTRL)) rd_mux = ctrl_rd[i];
      if (bus_addr == ADDR_W'(i * WIN_BYTES + OFS_LO))   rd_mux = reload[i][DATA_W-1:0];
      if (bus_addr == ADDR_W'(i * WIN_BYTES + OFS_HI))   rd_mux = DATA_W'(reload[i][CNT_W-1:DATA_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign cnt_end_o = cnt_end;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int NUM_CNT  = 2,
  parameter int ADDR_W   = 8,
  parameter int SEL_ADDR = 'h80
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NUM_CNT-1:0] cnt_end_o,
  input logic [NUM_CNT-1:0] sel_q,
  input logic               wdt_rst_o,
  input logic               wdt_flag_o
);
  // R7
  rst_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |=> !wdt_rst_o);

  // R7
  rst_needs_selected_end_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |-> $past(|(cnt_end_o & sel_q)));

  // R8
  flag_follows_rst_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |-> wdt_flag_o);

  // R8
  flag_clear_by_sel_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_flag_o) |-> $past(bus_wr && bus_addr == ADDR_W'(SEL_ADDR)));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_end
    // R3
    end_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_end_o[i] |=> !cnt_end_o[i]);
  end
endmodule

bind chained_wdt wdt_chk #(
  .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .cnt_end_o (cnt_end_o),
  .sel_q     (sel_q),
  .wdt_rst_o (wdt_rst_o),
  .wdt_flag_o(wdt_flag_o)
);

// File: tb/sim_chained_wdt.sv
`timescale 1ns/1ps
module sim_chained_wdt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cnt_end_o;
  logic        wdt_rst_o, wdt_flag_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  chained_wdt u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_end_o(cnt_end_o), .wdt_rst_o(wdt_rst_o), .wdt_flag_o(wdt_flag_o)
  );

  localparam int NVEC = 7;
  localparam int VEC_PS  [NVEC] = '{2, 2, 2, 3, 1, 0, 8};
  localparam int VEC_N   [NVEC] = '{0, 1, 5, 4, 3, 2, 2};
  localparam int VEC_EXP [NVEC] = '{3, 5, 13, 15, 9, 7, 19};

  localparam logic [7:0] A_C0 = 8'h00, A_L0 = 8'h04, A_H0 = 8'h08;
  localparam logic [7:0] A_C1 = 8'h10, A_L1 = 8'h14, A_H1 = 8'h18;
  localparam logic [7:0] A_SEL = 8'h80;

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // which: 0 = cnt_end_o[0], 1 = cnt_end_o[1], 2 = wdt_rst_o
  task automatic wait_evt(input int which, input int limit, output int n);
    n = 0;
    while (n < limit) begin
      if ((which == 0 && cnt_end_o[0]) || (which == 1 && cnt_end_o[1]) ||
          (which == 2 && wdt_rst_o)) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic kick();
    wr(A_C0, 32'h0000_0200);
    wr(A_C0, 32'h0000_0201);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    check(wdt_rst_o == 0 && wdt_flag_o == 0 && cnt_end_o == 0 && bus_rdata == 0,
          "R10 outputs", {wdt_rst_o, wdt_flag_o, cnt_end_o}, 0);
    rd(A_C1, d); check(d == 0, "R10 ctrl1", d, 0);
    rd(A_SEL, d); check(d == 0, "R10 select", d, 0);

    // R1 reload readback
    wr(A_L1, 32'hDEAD_BEEF); wr(A_H1, 32'h1234_5678);
    rd(A_L1, d); check(d == 32'hDEAD_BEEF, "R1 reload low", d, 32'hDEAD_BEEF);
    rd(A_H1, d); check(d == 32'h1234_5678, "R1 reload high", d, 32'h1234_5678);

    // R2/R5: triggered mode, enabled, no trigger -> running flag clear
    wr(A_C1, 32'h0000_035D);
    rd(A_C1, d); check(d == 32'h0000_035D, "R2 R5 ctrl readback idle", d, 32'h35D);
    wait_evt(1, 30, n); check(n == 30, "R5 no run without trigger", n, 30);
    wr(A_C1, 32'h0);

    // counter 0 reload 0 for kicking
    wr(A_L0, 0); wr(A_H0, 0); wr(A_H1, 0);

    // R6 R4 R7 R8 vector table
    for (int v = 0; v < NVEC; v++) begin
      wr(A_C1, 32'h0);
      wr(A_L1, VEC_N[v]);
      wr(A_SEL, 32'h2);
      wr(A_C1, (VEC_PS[v] << 8) | 32'h5D);
      kick();
      wait_evt(2, 200, n);
      check(n == VEC_EXP[v], "R6 R4 kick to reset interval", n, VEC_EXP[v]);
      check(wdt_flag_o == 1, "R8 flag with pulse", wdt_flag_o, 1);
      @(negedge clk);
      check(wdt_rst_o == 0, "R7 pulse one clock", wdt_rst_o, 0);
    end

    // R8 sticky until select write
    repeat (10) @(negedge clk);
    check(wdt_flag_o == 1, "R8 flag held", wdt_flag_o, 1);
    wr(A_SEL, 32'h2);
    check(wdt_flag_o == 0, "R8 flag cleared by select write", wdt_flag_o, 0);

    // R6 R5 retrigger while running: N=20 P=2 -> 43
    wr(A_C1, 32'h0); wr(A_L1, 20); wr(A_C1, 32'h025D);
    kick();
    repeat (20) @(negedge clk);
    rd(A_C1, d); check(d[1] == 1, "R5 running flag set", d[1], 1);
    check(wdt_flag_o == 0, "R6 no expiry before second kick", wdt_flag_o, 0);
    kick();
    wait_evt(2, 200, n); check(n == 43, "R6 restart on second kick", n, 43);

    // R7 select zero: counter ends, no reset
    wr(A_C1, 32'h0); wr(A_L1, 3); wr(A_SEL, 32'h0); wr(A_C1, 32'h025D);
    kick();
    wait_evt(1, 50, n); check(n == 8, "R7 counter1 still ends", n, 8);
    wait_evt(2, 20, n); check(n == 20 && wdt_flag_o == 0, "R7 no reset with select 0", n, 20);

    // R3 one-shot non-zero and zero reload
    wr(A_C1, 32'h0);
    wr(A_L0, 4); wr(A_C0, 32'h0300); wr(A_C0, 32'h0301);
    wait_evt(0, 100, n); check(n == 13, "R3 one-shot N=4 P=3", n, 13);
    wr(A_L0, 0); wr(A_C0, 32'h0300); wr(A_C0, 32'h0301);
    wait_evt(0, 20, n); check(n == 1, "R3 one-shot zero reload", n, 1);

    // R9 disable mid-run
    wr(A_L0, 10); wr(A_C0, 32'h0200); wr(A_C0, 32'h0201);
    repeat (5) @(negedge clk);
    wr(A_C0, 32'h0200);
    rd(A_C0, d); check(d == 32'h0200, "R9 running flag cleared", d, 32'h200);
    wait_evt(0, 40, n); check(n == 40, "R9 no end after disable", n, 40);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule